// File: doc/BRIEF.md
# I2C Command-Byte Sequencer

This block turns a stream of one-byte commands into bus activity on an open-drain two-wire serial bus. A command is one of two kinds. A line-control byte sets the SCL and SDA levels directly, or forces both lines to their released state, and can mark the end of a command list. A transfer byte can issue a START, move one byte in either direction, decide the acknowledge bit on reads and finish with a STOP. Data for a transfer comes from a byte port or from a single internal holding register, and goes back to one of them. Malformed commands are refused, and the block raises an error flag for them.

Software or a host engine supplies commands through a valid/ready handshake and sets a half-bit divider to match its clock rate. The block drives only the pull-low enables of the two lines and reads SDA back. One divider count gives each SCL phase, START, STOP and line-control step the same length. The FSM states are S_IDLE (ready for a command), S_SPC_SCL and S_SPC_SDA (line-control: SCL is applied first, then SDA), S_STA_A/B/C (START: release SDA, raise SCL, drop SDA, drop SCL), S_BIT_LO and S_BIT_HI (one SCL pulse per data or acknowledge bit, nine in all), S_BYTE_END (SCL low, SDA released) and S_STO_A/B/C (STOP: pull SDA low, raise SCL, release SDA). In S_IDLE an accepted command goes to S_SPC_SCL, S_STA_A or S_BIT_LO. The START path leads into S_BIT_LO. S_BIT_HI returns to S_BIT_LO until the ninth pulse, then goes to S_BYTE_END. From S_BYTE_END the FSM enters S_STO_A when a STOP was requested and returns to S_IDLE otherwise. The line-control and STOP paths end in S_IDLE.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset both line enables are low (lines released), cmd_ready is 1, busy, err, done and rd_valid are 0, and reg_q is 0.
- R2: A byte with bits[7:6]=11 is a line-control command. A byte with bit 6 = 0 is a transfer command. A byte with bits[7:6]=01 is illegal and sets err.
- R3: A line-control command with bit 4 = 1 sets SCL to bit 2 and then SDA to bit 3, each step lasting one half-bit. If bit 0 is 1, done pulses for one cycle when the command finishes. So 8'hFF leaves both lines released and 8'hF3 leaves both held low, and neither creates a START.
- R4: A line-control command with bit 4 = 0 releases both lines whatever bits 3 and 2 hold.
- R5: A line-control command with bit 1 = 0, or with bits 4, 3 and 2 all 0, is refused. err becomes 1 and neither line changes.
- R6: A transfer command with bit 0 = 1, or a read (bit 5 = 1) with bit 4 = 0 and bit 2 = 1, is refused with err = 1 and no bus activity. err returns to 0 when the next legal command is accepted.
- R7: With bit 7 set, a transfer first makes a START (SDA falls while SCL is high).
- R8: A write (bit 5 = 0) shifts 8 bits out MSB first. The source is wr_data (sampled at acceptance) when bit 4 = 1 and the internal register when bit 4 = 0. On the ninth pulse SDA is sampled, and nack shows 1 when it was high.
- R9: A read samples SDA at the end of each SCL high phase, MSB first. With bit 4 = 1 the byte appears on rd_data with a one-cycle rd_valid pulse. With bit 4 = 0 it is stored in the internal register, which is visible on reg_q.
- R10: On a read the block drives SDA low on the ninth pulse when bit 2 = 1 or bit 3 = 0. Otherwise it leaves SDA released.
- R11: Bit 3 alone decides STOP (SDA rises while SCL is high). Without it the byte ends with SCL held low and SDA released.
- R12: Every SCL high phase of a transfer lasts half_div+1 clock cycles (half_div must be at least 1).
- R13: cmd_ready is 1 only in S_IDLE. busy is 1 from the cycle after a legal command is accepted until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | 8 | Command byte |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| wr_data | input | 8 | Byte to send for a buffered write |
| rd_data | output | 8 | Byte received by a buffered read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| reg_q | output | 8 | Internal holding register |
| half_div | input | DIV_W | Half-bit length minus one, in clocks |
| busy | output | 1 | A command is executing |
| done | output | 1 | Pulse at the end of a quitting line-control command |
| err | output | 1 | Last accepted command was illegal |
| nack | output | 1 | Acknowledge bit of the last write was high |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
A bus-target model in the bench decodes START, STOP and the bit stream from the wired-AND lines, acknowledges or refuses writes, and supplies bytes for reads. Buffered writes with and without a target acknowledge separate the data path from the nack capture. A read into the register followed by a write from it shows that both directions reach the same storage. A buffered read that asks for an acknowledge without a STOP separates the acknowledge decision from the STOP decision. Randomized transfers vary the divider, data, direction, STOP and acknowledge bits. Directed line-control and illegal bytes confirm the end-of-list states, the kill behaviour, and that refused commands leave the bus untouched.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SPC_SCL,
        S_SPC_SDA,
        S_STA_A,
        S_STA_B,
        S_STA_C,
        S_BIT_LO,
        S_BIT_HI,
        S_BYTE_END,
        S_STO_A,
        S_STO_B,
        S_STO_C
    } seq_state_e;

    typedef struct packed {
        logic special;   // line-control command
        logic illegal;   // refused encoding
        logic quit;      // end of list
        logic lvl_sda;   // requested SDA level (1 = released)
        logic lvl_scl;   // requested SCL level (1 = released)
        logic start;     // START before transfer
        logic rd;        // 1 = read
        logic use_buf;   // 1 = data port, 0 = internal register
        logic stop;      // STOP after transfer
        logic ack_last;  // acknowledge request on read
    } cmd_dec_t;

endpackage

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
    import i2cseq_pkg::*;
(
    input  logic [7:0] cmd,
    output cmd_dec_t   dec
);
    logic is_spc;
    logic is_io;
    logic kill;

    always_comb begin
        is_spc = cmd[7] & cmd[6];
        is_io  = ~cmd[6];
        kill   = ~cmd[4];

        dec          = '0;
        dec.special  = is_spc;
        dec.quit     = cmd[0];
        dec.lvl_sda  = kill ? 1'b1 : cmd[3];
        dec.lvl_scl  = kill ? 1'b1 : cmd[2];
        dec.start    = cmd[7];
        dec.rd       = cmd[5];
        dec.use_buf  = cmd[4];
        dec.stop     = cmd[3];
        dec.ack_last = cmd[2];
        dec.illegal  = (~cmd[7] & cmd[6])
                     | (is_spc & (~cmd[1] | ~(cmd[4] | cmd[3] | cmd[2])))
                     | (is_io & (cmd[0] | (cmd[5] & ~cmd[4] & cmd[2])));
    end
endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R12: after a tick the next phase needs at least one more cycle
    p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2cseq_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic             cmd_ready,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [7:0]       reg_q,
    input  logic [DIV_W-1:0] half_div,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             nack,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int NBITS = 8;
    localparam int BCW   = $clog2(NBITS + 2);
    localparam logic [BCW-1:0] LASTB = BCW'(NBITS);

    seq_state_e       st, nx;
    cmd_dec_t         dec, cq;
    logic             tick;
    logic             lo_first;
    logic [BCW-1:0]   bitn;
    logic [NBITS-1:0] sh;
    logic [NBITS-1:0] reg_r;
    logic             scl_r, sda_r;
    logic             bit_level;
    logic             entering_lo;

    i2cseq_decode u_dec (
        .cmd (cmd_byte),
        .dec (dec)
    );

    i2cseq_timer #(.W(DIV_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st != S_IDLE),
        .div   (half_div),
        .tick  (tick)
    );

    assign cmd_ready = (st == S_IDLE);
    assign busy      = (st != S_IDLE);
    assign scl_oe    = ~scl_r;
    assign sda_oe    = ~sda_r;
    assign reg_q     = reg_r;

    // level put on SDA during the low phase of the current bit
    always_comb begin
        if (bitn < LASTB) begin
            bit_level = cq.rd ? 1'b1 : sh[NBITS-1];
        end else begin
            bit_level = cq.rd ? ~(cq.ack_last | ~cq.stop) : 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE: begin
                if (cmd_valid && !dec.illegal) begin
                    if (dec.special)    nx = S_SPC_SCL;
                    else if (dec.start) nx = S_STA_A;
                    else                nx = S_BIT_LO;
                end
            end
            S_SPC_SCL:  if (tick) nx = S_SPC_SDA;
            S_SPC_SDA:  if (tick) nx = S_IDLE;
            S_STA_A:    if (tick) nx = S_STA_B;
            S_STA_B:    if (tick) nx = S_STA_C;
            S_STA_C:    if (tick) nx = S_BIT_LO;
            S_BIT_LO:   if (tick) nx = S_BIT_HI;
            S_BIT_HI:   if (tick) nx = (bitn == LASTB) ? S_BYTE_END : S_BIT_LO;
            S_BYTE_END: if (tick) nx = cq.stop ? S_STO_A : S_IDLE;
            S_STO_A:    if (tick) nx = S_STO_B;
            S_STO_B:    if (tick) nx = S_STO_C;
            S_STO_C:    if (tick) nx = S_IDLE;
            default:    nx = S_IDLE;
        endcase
    end

    assign entering_lo = ((nx == S_BIT_LO) && (st != S_BIT_LO))
                      || ((nx == S_BYTE_END) && (st != S_BYTE_END));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_r    <= 1'b1;
            sda_r    <= 1'b1;
            cq       <= '0;
            sh       <= '0;
            reg_r    <= '0;
            bitn     <= '0;
            lo_first <= 1'b0;
            err      <= 1'b0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            nack     <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            lo_first <= entering_lo;
            unique case (st)
                S_IDLE: begin
                    if (cmd_valid) begin
                        cq  <= dec;
                        err <= dec.illegal;
                        if (!dec.illegal) begin
                            if (dec.special) begin
                                scl_r <= dec.lvl_scl;
                            end else begin
                                bitn <= '0;
                                sh   <= dec.use_buf ? wr_data : reg_r;
                                if (dec.start) sda_r <= 1'b1;
                                else           scl_r <= 1'b0;
                            end
                        end
                    end
                end
                S_SPC_SCL: if (tick) sda_r <= cq.lvl_sda;
                S_SPC_SDA: if (tick) done <= cq.quit;
                S_STA_A:   if (tick) scl_r <= 1'b1;
                S_STA_B:   if (tick) sda_r <= 1'b0;
                S_STA_C:   if (tick) scl_r <= 1'b0;
                S_BIT_LO: begin
                    if (lo_first) sda_r <= bit_level;
                    if (tick)     scl_r <= 1'b1;
                end
                S_BIT_HI: begin
                    if (tick) begin
                        scl_r <= 1'b0;
                        bitn  <= bitn + 1'b1;
                        if (bitn < LASTB) begin
                            sh <= {sh[NBITS-2:0], sda_in};
                        end else if (cq.rd) begin
                            if (cq.use_buf) begin
                                rd_data  <= sh;
                                rd_valid <= 1'b1;
                            end else begin
                                reg_r <= sh;
                            end
                        end else begin
                            nack <= sda_in;
                        end
                    end
                end
                S_BYTE_END: begin
                    if (lo_first)          sda_r <= 1'b1;
                    if (tick && cq.stop)   sda_r <= 1'b0;
                end
                S_STO_A: if (tick) scl_r <= 1'b1;
                S_STO_B: if (tick) sda_r <= 1'b1;
                S_STO_C: ;
                default: ;
            endcase
        end
    end

    // R11: SDA may rise under a high SCL on a transfer only for a requested STOP
    p_stop_needs_p_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_r && $past(scl_r) && $rose(sda_r) && !cq.special) |-> cq.stop);

    // R5, R6: a refused command leaves the FSM idle and the lines untouched
    p_illegal_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && dec.illegal) |=>
            (cmd_ready && err && $stable(scl_r) && $stable(sda_r)));

    // R13: a legal command makes the block busy on the next cycle
    p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !dec.illegal) |=> busy);

    // R3: done only follows the last step of a line-control command
    p_done_after_special_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == S_SPC_SDA && cmd_ready));

    // R8: SDA stays put while SCL is high inside a data bit
    p_sda_steady_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BIT_HI && $past(st) == S_BIT_HI) |-> $stable(sda_r));
endmodule

// File: tb/i2c_cmd_seq_tb.sv
`timescale 1ns/1ps
module i2c_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_ready;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  reg_q;
    logic [15:0] half_div = 16'd2;
    logic        busy, done, err, nack, scl_oe, sda_oe;
    logic        s_drv = 1'b0;
    wire         scl_line = ~scl_oe;
    wire         sda_line = ~(sda_oe | s_drv);

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    i2c_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_ready(cmd_ready), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .reg_q(reg_q), .half_div(half_div), .busy(busy),
        .done(done), .err(err), .nack(nack), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_in(sda_line)
    );

    // bus-target model
    int   starts = 0, stops = 0, s_bitn = 0, s_left = 0;
    bit   s_mode_rd = 0, s_ack_en = 1, s_mack = 1;
    logic [7:0] s_tx = '0, s_rx = '0, s_got = '0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin starts++; s_bitn = 0; end
    always @(posedge sda_line) if (scl_line === 1'b1) stops++;
    always @(posedge scl_line) begin
        if (s_bitn < 8) s_rx = {s_rx[6:0], sda_line};
        else begin
            s_got  = s_rx;
            s_mack = sda_line;
            if (s_left > 0) s_left--;
        end
        s_bitn = (s_bitn >= 8) ? 0 : s_bitn + 1;
    end
    always @(negedge scl_line) begin
        s_drv = 1'b0;
        if (s_left > 0) begin
            if (s_mode_rd && s_bitn < 8) s_drv = ~s_tx[7 - s_bitn];
            else if (!s_mode_rd && s_bitn == 8) s_drv = s_ack_en;
        end
    end

    // sticky flags and SCL high-phase length
    bit done_seen = 0, rv_seen = 0, busy_after = 0;
    logic [7:0] rv_data = '0;
    int hcnt = 0, last_hi = 0;
    always @(posedge clk) begin
        if (done) done_seen <= 1'b1;
        if (rd_valid) begin rv_seen <= 1'b1; rv_data <= rd_data; end
    end
    always @(negedge clk) begin
        if (scl_line === 1'b1) hcnt++;
        else if (hcnt != 0) begin last_hi = hcnt; hcnt = 0; end
    end

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] c);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_byte  = c;
        cmd_valid = 1'b1;
        done_seen = 0;
        rv_seen   = 0;
        @(negedge clk);
        cmd_valid  = 1'b0;
        busy_after = busy;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] f_wr(input bit p);
        return 8'h90 | (8'(p) << 3);
    endfunction
    function automatic logic [7:0] f_rd(input bit p, input bit a);
        return 8'hB0 | (8'(p) << 3) | (8'(a) << 2);
    endfunction
    function automatic bit f_mack(input bit p, input bit a);
        return !(a || !p);   // line level the target sees on the ninth pulse
    endfunction

    task automatic bus_write(input logic [7:0] c, input logic [7:0] d, input bit ack);
        s_mode_rd = 0; s_ack_en = ack; s_left = 1; wr_data = d;
        do_cmd(c);
    endtask
    task automatic bus_read(input logic [7:0] c, input logic [7:0] d);
        s_mode_rd = 1; s_tx = d; s_left = 1;
        do_cmd(c);
    endtask

    initial begin
        int st0, sp0;
        logic [7:0] ill [5];
        string ill_req [5];
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl_oe == 0 && sda_oe == 0, "R1 lines", {scl_oe, sda_oe}, 0);
        check(cmd_ready && !busy && !err && !done && !rd_valid && reg_q == 0,
              "R1 flags", {cmd_ready, busy, err, done, rd_valid}, 5'b10000);
        starts = 0; stops = 0; s_bitn = 0;

        // R7 R8 R11 R12 R13: buffered write with START and STOP, target acks
        st0 = starts; sp0 = stops;
        bus_write(8'h98, 8'hA5, 1);
        check(s_got == 8'hA5, "R8 write data", s_got, 8'hA5);
        check(nack == 0, "R8 ack seen", nack, 0);
        check(starts == st0 + 1, "R7 start", starts, st0 + 1);
        check(stops == sp0 + 1, "R11 stop", stops, sp0 + 1);
        check(busy_after == 1, "R13 busy after accept", busy_after, 1);
        check(last_hi == 3, "R12 high phase", last_hi, 3);
        check(scl_oe == 0 && sda_oe == 0, "R11 released after stop", {scl_oe, sda_oe}, 0);

        // R8 nack
        bus_write(8'h98, 8'h5A, 0);
        check(nack == 1, "R8 nack", nack, 1);

        // R9 R10 read into register, P=1 A=0 -> released acknowledge
        bus_read(8'hA8, 8'h3C);
        check(reg_q == 8'h3C, "R9 register read", reg_q, 8'h3C);
        check(rv_seen == 0, "R9 no rd_valid for register", rv_seen, 0);
        check(s_mack == 1, "R10 release on last", s_mack, 1);

        // R8 write sourced from register
        bus_write(8'h88, 8'h00, 1);
        check(s_got == 8'h3C, "R8 register source", s_got, 8'h3C);

        // R9 R10 R11 buffered read with ack and no stop
        sp0 = stops;
        bus_read(8'hB4, 8'h96);
        check(rv_seen && rv_data == 8'h96, "R9 buffered read", rv_data, 8'h96);
        check(s_mack == 0, "R10 ack driven", s_mack, 0);
        check(stops == sp0, "R11 no stop without bit3", stops, sp0);
        check(scl_oe == 1 && sda_oe == 0, "R11 scl held low", {scl_oe, sda_oe}, 2'b10);

        // R3 end of list, release
        do_cmd(8'hFF);
        check(scl_oe == 0 && sda_oe == 0, "R3 FF releases", {scl_oe, sda_oe}, 0);
        check(done_seen == 1, "R3 done on quit", done_seen, 1);

        // R3 end of list, hold low
        st0 = starts;
        do_cmd(8'hF3);
        check(scl_oe == 1 && sda_oe == 1, "R3 F3 holds low", {scl_oe, sda_oe}, 2'b11);
        check(done_seen == 1 && starts == st0, "R3 F3 done no start", starts, st0);

        // R4 kill
        do_cmd(8'hC6);
        check(scl_oe == 0 && sda_oe == 0, "R4 kill releases", {scl_oe, sda_oe}, 0);
        check(done_seen == 0, "R4 no done without quit", done_seen, 0);

        // R2 R5 R6 illegal commands
        ill[0] = 8'hF5; ill_req[0] = "R5 bit1 clear";
        ill[1] = 8'hC2; ill_req[1] = "R5 V D C zero";
        ill[2] = 8'h99; ill_req[2] = "R6 bit0 set";
        ill[3] = 8'hA4; ill_req[3] = "R6 register read with ack";
        ill[4] = 8'h40; ill_req[4] = "R2 bits 01";
        for (int i = 0; i < 5; i++) begin
            st0 = starts; sp0 = stops;
            do_cmd(ill[i]);
            check(err == 1, ill_req[i], err, 1);
            check(scl_oe == 0 && sda_oe == 0 && starts == st0 && stops == sp0,
                  ill_req[i], {scl_oe, sda_oe}, 0);
        end
        do_cmd(8'hFF);
        check(err == 0, "R6 err clears", err, 0);

        // randomized transfers
        for (int it = 0; it < 24; it++) begin
            bit rd, p, a, ack;
            logic [7:0] d;
            logic [15:0] dv;
            rd  = 1'($urandom_range(0, 1));
            p   = 1'($urandom_range(0, 1));
            a   = 1'($urandom_range(0, 1));
            ack = 1'($urandom_range(0, 1));
            d   = 8'($urandom_range(0, 255));
            dv  = 16'($urandom_range(1, 4));
            half_div = dv;
            st0 = starts; sp0 = stops;
            if (rd) begin
                bus_read(f_rd(p, a), d);
                check(rv_seen && rv_data == d, "R9 random read", rv_data, d);
                check(s_mack == f_mack(p, a), "R10 random ack", s_mack, f_mack(p, a));
            end else begin
                bus_write(f_wr(p), d, ack);
                check(s_got == d, "R8 random write", s_got, d);
                check(nack == !ack, "R8 random nack", nack, !ack);
            end
            check(starts == st0 + 1, "R7 random start", starts, st0 + 1);
            check(stops == sp0 + int'(p), "R11 random stop", stops, sp0 + int'(p));
            check(last_hi == int'(dv) + 1, "R12 random phase", last_hi, int'(dv) + 1);
        end
        do_cmd(8'hFF);
        summary_and_end();
    end
endmodule